// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Logic

This block sits between an instruction decode queue and two parallel integer execution pipes. Each cycle it looks at the two oldest decoded instructions, called the lead and the trail. It decides whether both can start together. The primary pipe accepts any instruction. The secondary pipe accepts only instructions classed as simple, and it only ever receives the trail, which is the instruction directly after the lead in program order. A pair is refused when either instruction is complex or when the two share a register hazard. A refused pair sends the lead alone to the primary pipe.

The candidate side follows a stream rule. The two candidate valid bits act as the offered items. `take_o` is the combinational ready answer: it reports how many candidates (0, 1 or 2) are consumed at the coming clock edge, always counted from the lead. A refused trail is not consumed, so the queue presents it as the lead of the next cycle. The trail can only be offered while the lead is offered. The issue side is registered and shaped as a stream towards both pipes. `stall_i` is the downstream back-pressure. While it is high, nothing is consumed and both pipe stages hold their contents, so a pair advances or waits as one unit.

Each descriptor carries the following fields:
- a simple/complex class bit;
- a write-enable bit;
- a destination register index;
- a set of source register indices;
- an opaque payload that travels to the chosen pipe.

Top module: `dual_issue_pair`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `u_vld_o`, `v_vld_o`, `adv_o` and `cnt_o` are all 0.
- R2: While `stall_i` is 1, `take_o` is 0. At the next edge the primary and secondary outputs keep their previous valid and payload values, and `adv_o` and `cnt_o` become 0.
- R3: When the lead is not valid, `take_o` is 0 and no pipe is loaded, whatever the trail inputs are.
- R4: When only the lead is valid, `take_o` is 1 and the lead alone is loaded into the primary pipe.
- R5: When both candidates are valid and simple and no hazard exists, `take_o` is 2. The lead is loaded into the primary pipe and the trail into the secondary pipe.
- R6: A complex lead (class bit 0) never pairs. It is loaded alone into the primary pipe with `take_o` equal to 1.
- R7: A complex trail is never loaded into the secondary pipe. Only the lead issues, with `take_o` equal to 1.
- R8: If the lead writes a register (write bit 1) whose index equals any source index of the trail, this is a read-after-write hazard. The pair is refused and `take_o` is 1.
- R9: If both candidates write and their destination indices are equal, this is a write-after-write hazard. The pair is refused and `take_o` is 1.
- R10: A lead with write bit 0 raises no hazard, even when its destination index equals a source or destination index of the trail.
- R11: `v_vld_o` is never 1 unless `u_vld_o` is 1. Whenever `adv_o` is 1, `cnt_o` equals the number of pipes loaded at that edge.
- R12: The issue outputs are registered. A decision made with `take_o` equal to n appears on the pipe outputs one cycle later, with `adv_o` 1 and `cnt_o` n. A cycle with n equal to 0 gives `adv_o` 0 and clears both pipe valids.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| c0_vld_i | input | 1 | Lead candidate present |
| c0_smp_i | input | 1 | Lead is simple (1) or complex (0) |
| c0_wr_i | input | 1 | Lead writes its destination |
| c0_dst_i | input | RW | Lead destination register index |
| c0_src_i | input | NSRC*RW | Lead source indices, source k at bits k*RW |
| c0_dat_i | input | DW | Lead payload |
| c1_vld_i | input | 1 | Trail candidate present |
| c1_smp_i | input | 1 | Trail is simple (1) or complex (0) |
| c1_wr_i | input | 1 | Trail writes its destination |
| c1_dst_i | input | RW | Trail destination register index |
| c1_src_i | input | NSRC*RW | Trail source indices, source k at bits k*RW |
| c1_dat_i | input | DW | Trail payload |
| stall_i | input | 1 | Downstream back-pressure; holds both pipes |
| take_o | output | 2 | Candidates consumed at the coming edge (0, 1, 2) |
| u_vld_o | output | 1 | Primary pipe holds an instruction |
| u_dat_o | output | DW | Primary pipe payload |
| v_vld_o | output | 1 | Secondary pipe holds an instruction |
| v_dat_o | output | DW | Secondary pipe payload |
| cnt_o | output | 2 | Instructions loaded at the last edge |
| adv_o | output | 1 | Both pipes advanced together at the last edge |

## Verification
The bench checks the hazard comparison on each source operand separately. A design that compared only the first source would pair an instruction that reads the lead's result through its second operand. It also checks write-after-write against a lead that does not write. This catches a design that ignores the write bit, which would refuse valid pairs, and a design that skips the WAW check, which would let both pipes retire the same register. The bench drives a valid trail behind an empty lead to expose a design that issues out of order. Stall cycles with a pair in flight show whether the pipes keep their contents and whether the candidate count stays at zero. Without that, a pair would be lost or consumed twice.

// File: rtl/pair_pkg.sv
package pair_pkg;

  // Issue decision. The numeric value equals the number of candidates consumed.
  typedef enum logic [1:0] {
    ISS_NONE = 2'd0,
    ISS_SOLO = 2'd1,
    ISS_PAIR = 2'd2
  } iss_e;

  localparam int unsigned DEF_RW   = 5;
  localparam int unsigned DEF_NSRC = 2;
  localparam int unsigned DEF_DW   = 32;

endpackage

// File: rtl/pair_hazard.sv
module pair_hazard #(
  parameter int unsigned RW   = 5,
  parameter int unsigned NSRC = 2
) (
  input  logic               lead_wr_i,
  input  logic [RW-1:0]      lead_dst_i,
  input  logic               trail_wr_i,
  input  logic [RW-1:0]      trail_dst_i,
  input  logic [NSRC*RW-1:0] trail_src_i,
  output logic               raw_o,
  output logic               waw_o
);

  logic [NSRC-1:0] src_hit;

  // one comparator per trail source operand
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign src_hit[g] = (trail_src_i[g*RW +: RW] == lead_dst_i);
  end

  assign raw_o = lead_wr_i & (|src_hit);
  assign waw_o = lead_wr_i & trail_wr_i & (lead_dst_i == trail_dst_i);

  // a lead that writes nothing can create no hazard
  always_comb begin
    if (!lead_wr_i) begin
      AST_NO_HAZARD_WITHOUT_WRITE: assert (!raw_o && !waw_o); // R10
    end
  end

endmodule

// File: rtl/pair_arbiter.sv
module pair_arbiter
  import pair_pkg::*;
(
  input  logic lead_vld_i,
  input  logic lead_smp_i,
  input  logic trail_vld_i,
  input  logic trail_smp_i,
  input  logic raw_i,
  input  logic waw_i,
  input  logic stall_i,
  output iss_e dec_o
);

  logic pair_ok;

  // both simple, both present, no register conflict
  assign pair_ok = lead_vld_i & trail_vld_i & lead_smp_i & trail_smp_i
                 & ~raw_i & ~waw_i;

  always_comb begin
    if (stall_i || !lead_vld_i) begin
      dec_o = ISS_NONE;
    end else if (pair_ok) begin
      dec_o = ISS_PAIR;
    end else begin
      dec_o = ISS_SOLO;
    end
  end

  always_comb begin
    if (stall_i) begin
      AST_STALL_TAKES_NOTHING: assert (dec_o == ISS_NONE); // R2
    end
    if (!lead_vld_i) begin
      AST_EMPTY_LEAD_NO_ISSUE: assert (dec_o == ISS_NONE); // R3
    end
    if (dec_o == ISS_PAIR) begin
      AST_PAIR_ONLY_SIMPLE: assert (lead_smp_i && trail_smp_i); // R7
      AST_PAIR_NO_HAZARD: assert (!raw_i && !waw_i); // R8
    end
  end

endmodule

// File: rtl/pair_issue_reg.sv
module pair_issue_reg
  import pair_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall_i,
  input  iss_e          dec_i,
  input  logic [DW-1:0] lead_dat_i,
  input  logic [DW-1:0] trail_dat_i,
  output logic          u_vld_o,
  output logic [DW-1:0] u_dat_o,
  output logic          v_vld_o,
  output logic [DW-1:0] v_dat_o,
  output logic [1:0]    cnt_o,
  output logic          adv_o
);

  logic load_u;
  logic load_v;

  assign load_u = (dec_i != ISS_NONE);
  assign load_v = (dec_i == ISS_PAIR);

  // both pipe stages share one enable: lockstep movement
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      u_vld_o <= 1'b0;
      u_dat_o <= '0;
      v_vld_o <= 1'b0;
      v_dat_o <= '0;
      cnt_o   <= 2'd0;
      adv_o   <= 1'b0;
    end else begin
      if (!stall_i) begin
        u_vld_o <= load_u;
        u_dat_o <= load_u ? lead_dat_i : '0;
        v_vld_o <= load_v;
        v_dat_o <= load_v ? trail_dat_i : '0;
      end
      cnt_o <= stall_i ? 2'd0 : dec_i;
      adv_o <= ~stall_i & load_u;
    end
  end

  AST_STALL_HOLDS_PIPES: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> $stable(u_vld_o) && $stable(v_vld_o) && $stable(u_dat_o)
                && $stable(v_dat_o) && !adv_o); // R2

  AST_SECONDARY_NEEDS_PRIMARY: assert property (@(posedge clk) disable iff (!rst_n)
    v_vld_o |-> u_vld_o); // R11

  AST_COUNT_MATCHES_PIPES: assert property (@(posedge clk) disable iff (!rst_n)
    adv_o |-> (cnt_o == {1'b0, u_vld_o} + {1'b0, v_vld_o})); // R11

  AST_ADVANCE_FOLLOWS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && dec_i != ISS_NONE) |=> adv_o && u_vld_o); // R12

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> !u_vld_o && !v_vld_o && !adv_o); // R1

endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
  import pair_pkg::*;
#(
  parameter int unsigned RW   = DEF_RW,
  parameter int unsigned NSRC = DEF_NSRC,
  parameter int unsigned DW   = DEF_DW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               c0_vld_i,
  input  logic               c0_smp_i,
  input  logic               c0_wr_i,
  input  logic [RW-1:0]      c0_dst_i,
  input  logic [NSRC*RW-1:0] c0_src_i,
  input  logic [DW-1:0]      c0_dat_i,
  input  logic               c1_vld_i,
  input  logic               c1_smp_i,
  input  logic               c1_wr_i,
  input  logic [RW-1:0]      c1_dst_i,
  input  logic [NSRC*RW-1:0] c1_src_i,
  input  logic [DW-1:0]      c1_dat_i,
  input  logic               stall_i,
  output logic [1:0]         take_o,
  output logic               u_vld_o,
  output logic [DW-1:0]      u_dat_o,
  output logic               v_vld_o,
  output logic [DW-1:0]      v_dat_o,
  output logic [1:0]         cnt_o,
  output logic               adv_o
);

  logic raw;
  logic waw;
  iss_e dec;

  // the lead's sources never matter for pairing: only the trail reads after it
  logic [NSRC*RW-1:0] lead_src_unused;
  assign lead_src_unused = c0_src_i;

  pair_hazard #(
    .RW   (RW),
    .NSRC (NSRC)
  ) i_hazard (
    .lead_wr_i   (c0_wr_i),
    .lead_dst_i  (c0_dst_i),
    .trail_wr_i  (c1_wr_i),
    .trail_dst_i (c1_dst_i),
    .trail_src_i (c1_src_i),
    .raw_o       (raw),
    .waw_o       (waw)
  );

  pair_arbiter i_arbiter (
    .lead_vld_i  (c0_vld_i),
    .lead_smp_i  (c0_smp_i),
    .trail_vld_i (c1_vld_i),
    .trail_smp_i (c1_smp_i),
    .raw_i       (raw),
    .waw_i       (waw),
    .stall_i     (stall_i),
    .dec_o       (dec)
  );

  pair_issue_reg #(
    .DW (DW)
  ) i_issue (
    .clk         (clk),
    .rst_n       (rst_n),
    .stall_i     (stall_i),
    .dec_i       (dec),
    .lead_dat_i  (c0_dat_i),
    .trail_dat_i (c1_dat_i),
    .u_vld_o     (u_vld_o),
    .u_dat_o     (u_dat_o),
    .v_vld_o     (v_vld_o),
    .v_dat_o     (v_dat_o),
    .cnt_o       (cnt_o),
    .adv_o       (adv_o)
  );

  assign take_o = dec;

  AST_TAKE_NOT_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    take_o != 2'd3); // R5

  AST_COMPLEX_LEAD_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (c0_vld_i && !c0_smp_i && !stall_i) |-> take_o == 2'd1); // R6

endmodule

// File: tb/test_dual_issue_pair.sv
module test_dual_issue_pair;

  localparam int CLK_PERIOD = 10;
  localparam int RW = 5;
  localparam int NSRC = 2;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic c0_vld = 0, c0_smp = 0, c0_wr = 0;
  logic [RW-1:0] c0_dst = '0;
  logic [NSRC*RW-1:0] c0_src = '0;
  logic [DW-1:0] c0_dat = '0;
  logic c1_vld = 0, c1_smp = 0, c1_wr = 0;
  logic [RW-1:0] c1_dst = '0;
  logic [NSRC*RW-1:0] c1_src = '0;
  logic [DW-1:0] c1_dat = '0;
  logic stall = 0;
  logic [1:0] take;
  logic u_vld, v_vld, adv;
  logic [DW-1:0] u_dat, v_dat;
  logic [1:0] cnt;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [DW-1:0] seq = 32'h100;

  typedef struct packed {
    logic          uv;
    logic [DW-1:0] ud;
    logic          vv;
    logic [DW-1:0] vd;
    logic [1:0]    cn;
    logic          ad;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  exp_t  model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_issue_pair i_dual_issue_pair (
    .clk(clk), .rst_n(rst_n),
    .c0_vld_i(c0_vld), .c0_smp_i(c0_smp), .c0_wr_i(c0_wr), .c0_dst_i(c0_dst),
    .c0_src_i(c0_src), .c0_dat_i(c0_dat),
    .c1_vld_i(c1_vld), .c1_smp_i(c1_smp), .c1_wr_i(c1_wr), .c1_dst_i(c1_dst),
    .c1_src_i(c1_src), .c1_dat_i(c1_dat),
    .stall_i(stall), .take_o(take),
    .u_vld_o(u_vld), .u_dat_o(u_dat), .v_vld_o(v_vld), .v_dat_o(v_dat),
    .cnt_o(cnt), .adv_o(adv)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: applies one candidate pair, checks take, pushes expected pipe state
  task automatic step(input logic v0, s0, w0, input logic [RW-1:0] d0,
                      input logic v1, s1, w1, input logic [RW-1:0] d1,
                      input logic [RW-1:0] a1, b1, input logic st, input string tag);
    logic pair;
    logic [1:0] et;
    @(negedge clk);
    c0_vld = v0; c0_smp = s0; c0_wr = w0; c0_dst = d0; c0_src = {5'd30, 5'd29};
    c1_vld = v1; c1_smp = s1; c1_wr = w1; c1_dst = d1; c1_src = {b1, a1};
    c0_dat = seq; c1_dat = seq + 32'h1000; seq = seq + 1;
    stall = st;
    #1;
    pair = v0 && v1 && s0 && s1
           && !(w0 && (d0 == a1 || d0 == b1))
           && !(w0 && w1 && d0 == d1);
    et = (st || !v0) ? 2'd0 : (pair ? 2'd2 : 2'd1);
    chk({tag, " take"}, {30'd0, take}, {30'd0, et});
    if (!st) begin
      model.uv = (et != 0);
      model.ud = c0_dat;
      model.vv = (et == 2);
      model.vd = c1_dat;
      model.cn = et;
      model.ad = (et != 0);
    end else begin
      model.cn = 2'd0;
      model.ad = 1'b0;
    end
    expq.push_back(model);
    tagq.push_back(tag);
  endtask

  // monitor: compares registered outputs just after each edge
  always @(posedge clk) begin
    #2;
    if (expq.size() > 0) begin
      exp_t e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      chk({t, " u_vld"}, {31'd0, u_vld}, {31'd0, e.uv});
      chk({t, " v_vld"}, {31'd0, v_vld}, {31'd0, e.vv});
      chk({t, " cnt"}, {30'd0, cnt}, {30'd0, e.cn});
      chk({t, " adv"}, {31'd0, adv}, {31'd0, e.ad});
      if (e.uv) chk({t, " u_dat"}, u_dat, e.ud);
      if (e.vv) chk({t, " v_dat"}, v_dat, e.vd);
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset u_vld", {31'd0, u_vld}, 0);
    chk("R1 reset v_vld", {31'd0, v_vld}, 0);
    chk("R1 reset adv", {31'd0, adv}, 0);
    chk("R1 reset cnt", {30'd0, cnt}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    chk("R1 after reset u_vld", {31'd0, u_vld}, 0);

    // v0 s0 w0 d0   v1 s1 w1 d1  a1 b1  st
    step(0, 1, 1, 5'd1, 1, 1, 1, 5'd2, 5'd3, 5'd4, 0, "R3 empty lead");
    step(1, 1, 1, 5'd1, 0, 1, 1, 5'd2, 5'd3, 5'd4, 0, "R4 lead only");
    step(1, 1, 1, 5'd1, 1, 1, 1, 5'd2, 5'd3, 5'd4, 0, "R5 pair");
    step(1, 1, 0, 5'd7, 1, 1, 1, 5'd8, 5'd9, 5'd10, 0, "R5 R12 pair again");
    step(1, 0, 1, 5'd1, 1, 1, 1, 5'd2, 5'd3, 5'd4, 0, "R6 complex lead");
    step(1, 1, 1, 5'd1, 1, 0, 1, 5'd2, 5'd3, 5'd4, 0, "R7 complex trail");
    step(1, 1, 1, 5'd6, 1, 1, 1, 5'd2, 5'd6, 5'd4, 0, "R8 raw src0");
    step(1, 1, 1, 5'd6, 1, 1, 0, 5'd2, 5'd3, 5'd6, 0, "R8 raw src1");
    step(1, 1, 1, 5'd9, 1, 1, 1, 5'd9, 5'd3, 5'd4, 0, "R9 waw");
    step(1, 1, 1, 5'd9, 1, 1, 0, 5'd9, 5'd3, 5'd4, 0, "R9 trail no write pairs");
    step(1, 1, 0, 5'd6, 1, 1, 1, 5'd6, 5'd6, 5'd6, 0, "R10 lead no write");
    step(1, 1, 1, 5'd11, 1, 1, 1, 5'd12, 5'd13, 5'd14, 0, "R2 pair before stall");
    step(1, 1, 1, 5'd1, 1, 1, 1, 5'd2, 5'd3, 5'd4, 1, "R2 stall hold");
    step(1, 0, 1, 5'd1, 1, 1, 1, 5'd2, 5'd3, 5'd4, 1, "R2 stall hold two");
    step(1, 1, 1, 5'd1, 1, 1, 1, 5'd2, 5'd3, 5'd4, 0, "R2 stall release");
    step(0, 0, 0, 5'd0, 0, 0, 0, 5'd0, 5'd0, 5'd0, 0, "R11 R12 idle");
    step(1, 1, 1, 5'd3, 0, 0, 0, 5'd0, 5'd0, 5'd0, 0, "R11 solo after idle");
    step(0, 0, 0, 5'd0, 0, 0, 0, 5'd0, 5'd0, 5'd0, 1, "R2 stall on empty");
    step(0, 0, 0, 5'd0, 0, 0, 0, 5'd0, 5'd0, 5'd0, 0, "R12 drain");

    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule